// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits beside a parallel NOR-style flash front end and watches every bus write cycle, with its address and data. It recognises the multi-cycle command sequences that software issues, and from them it sets which kind of data the read path must return: the memory array, the query/identification area, the auto-select status words, or the program controller's status. When a sequence that carries operands completes, the block raises a one-cycle start strobe. For a single-word program, a two-word or four-word program, or a configuration write, the latched address and data words are held on the operand outputs during that strobe.

Most commands begin with two fixed unlock writes. A bypass state lets two-word programs be issued repeatedly without them. Multi-word program operands are checked for a common base address. Any write that does not fit the sequence in progress discards it and puts the read path back to array data. While the external program controller reports busy, writes are not interpreted at all.

Top module: `fcmd_decoder`

## Requirements
- R1: After synchronous reset, rd_mode_o is array (0), every start strobe is low and cfg_pd_o is 0. When there is no accepted write, no strobe rises and rd_mode_o holds its value.
- R2: An unlock pair is a write with address[10:0]=0x555 and data[7:0]=0xAA, followed by a write with address[10:0]=0x2AA and data[7:0]=0x55. Only those bits are compared, and the setup write that follows may go to any address. The setup codes (data[7:0]) are: 0xF0 reset, 0x90 auto-select, 0x60 configuration, 0xA0 program, 0x50 two-word, 0x56 four-word and 0x20 bypass entry.
- R3: A write that does not continue the sequence in progress abandons it, sets rd_mode_o to array and raises no strobe.
- R4: A write of 0xF0, issued alone or after an unlock pair, sets rd_mode_o to array.
- R5: A single write of 0x98 outside any sequence sets rd_mode_o to query (1). In query or auto-select mode, the next write of any value returns rd_mode_o to array and starts no sequence.
- R6: An unlock pair followed by 0x90 sets rd_mode_o to auto-select (2).
- R7: An unlock pair, then 0x60, then one more write gives cfg_start_o high for the one cycle after that write. op_addr_o then equals that write's address, cfg_pd_o takes address bit 10, and rd_mode_o is array.
- R8: An unlock pair, then 0xA0, then one operand write gives pgm_start_o high for the one cycle after it. op_addr_o is the operand address, word 0 of op_data_o is its data, and the other words are 0. rd_mode_o becomes status (3) and stays there until R3 or R4 applies.
- R9: An unlock pair, then 0x50, then two operand writes whose addresses differ at most in bit 0 gives dwp_start_o for one cycle after the second write. op_addr_o is the first address, words 0 and 1 hold the data in write order, and rd_mode_o becomes status.
- R10: An unlock pair, then 0x56, then four operand writes whose addresses differ at most in bits 1:0 gives qwp_start_o for one cycle after the fourth write. Words 0 to 3 hold the data in write order, and rd_mode_o becomes status.
- R11: An operand write after the first of a two-word or four-word program whose address differs from the first outside the ignored low bits aborts the command. The block returns to array mode, leaves bypass and raises no strobe.
- R12: An unlock pair then 0x20 enters bypass. In bypass, 0x50 alone starts a two-word program, and the block returns to bypass when it completes. Any other write in bypass, including 0xF0, leaves bypass and sets array mode.
- R13: A write presented while busy_i is high changes neither state nor outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | One-cycle bus write strobe |
| wr_addr_i | input | AW (21) | Write address |
| wr_data_i | input | DW (16) | Write data |
| busy_i | input | 1 | Program controller busy |
| rd_mode_o | output | 2 | Read mode: 0 array, 1 query, 2 auto-select, 3 status |
| pgm_start_o | output | 1 | Single-word program start |
| dwp_start_o | output | 1 | Two-word program start |
| qwp_start_o | output | 1 | Four-word program start |
| cfg_start_o | output | 1 | Configuration write start |
| op_addr_o | output | AW (21) | Latched operand (first) address |
| op_data_o | output | NW*DW (64) | Latched operand words, word k at bits k*DW upward |
| cfg_pd_o | output | 1 | Configuration bit: 0 reset function, 1 power-down |

## Verification
Clean sequences for every command are compared with near-misses built from them. An unlock write with a wrong address or data tells exact matching apart from loose matching. Unlock writes whose upper address and data bits are set confirm that only the low fields are compared. Two-word and four-word bursts are run once with agreeing addresses and once with a mismatch in the second or third word, which separates the abort from a completed start. Bypass is exercised with back-to-back two-word bursts and then after leaving it, and busy is raised in the middle of an unlock pair to show that writes made while busy leave the sequence intact.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_QUERY  = 2'd1,
    RM_ASEL   = 2'd2,
    RM_STATUS = 2'd3
  } rmode_t;

  typedef enum logic [3:0] {
    CK_NONE, CK_RESET, CK_QUERY, CK_ASEL, CK_CFG, CK_PGM, CK_DWP, CK_QWP, CK_BYP
  } cmd_t;

  localparam logic [10:0] UNL1_ADDR = 11'h555;
  localparam logic [10:0] UNL2_ADDR = 11'h2AA;
  localparam logic [7:0]  UNL1_DATA = 8'hAA;
  localparam logic [7:0]  UNL2_DATA = 8'h55;
  localparam logic [7:0]  CODE_RESET = 8'hF0;
  localparam logic [7:0]  CODE_QUERY = 8'h98;
  localparam logic [7:0]  CODE_ASEL  = 8'h90;
  localparam logic [7:0]  CODE_CFG   = 8'h60;
  localparam logic [7:0]  CODE_PGM   = 8'hA0;
  localparam logic [7:0]  CODE_DWP   = 8'h50;
  localparam logic [7:0]  CODE_QWP   = 8'h56;
  localparam logic [7:0]  CODE_BYP   = 8'h20;
endpackage

// File: rtl/fcmd_classify.sv
module fcmd_classify
  import fcmd_pkg::*;
#(
  parameter int CMP_W = 11
) (
  input  logic [CMP_W-1:0] addr_i,
  input  logic [7:0]       code_i,
  output logic             is_unl1_o,
  output logic             is_unl2_o,
  output cmd_t             cmd_o
);
  assign is_unl1_o = (addr_i == CMP_W'(UNL1_ADDR)) && (code_i == UNL1_DATA);
  assign is_unl2_o = (addr_i == CMP_W'(UNL2_ADDR)) && (code_i == UNL2_DATA);

  always_comb begin
    unique case (code_i)
      CODE_RESET: cmd_o = CK_RESET;
      CODE_QUERY: cmd_o = CK_QUERY;
      CODE_ASEL:  cmd_o = CK_ASEL;
      CODE_CFG:   cmd_o = CK_CFG;
      CODE_PGM:   cmd_o = CK_PGM;
      CODE_DWP:   cmd_o = CK_DWP;
      CODE_QWP:   cmd_o = CK_QWP;
      CODE_BYP:   cmd_o = CK_BYP;
      default:    cmd_o = CK_NONE;
    endcase
  end
endmodule

// File: rtl/fcmd_operand_buf.sv
module fcmd_operand_buf #(
  parameter int AW = 21,
  parameter int DW = 16,
  parameter int NW = 4,
  localparam int IW = $clog2(NW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_i,
  input  logic [IW-1:0]   idx_i,
  input  logic            quad_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   data_i,
  output logic            mismatch_o,
  output logic [AW-1:0]   base_o,
  output logic [NW*DW-1:0] words_o
);
  logic [AW-1:0] ign_mask;
  logic [AW-1:0] base_q;

  assign ign_mask   = quad_i ? AW'(NW - 1) : AW'(1);
  assign mismatch_o = ((addr_i ^ base_q) & ~ign_mask) != '0;
  assign base_o     = base_q;

  always_ff @(posedge clk) begin
    if (rst)                          base_q <= '0;
    else if (cap_i && idx_i == '0)    base_q <= addr_i;
  end

  for (genvar g = 0; g < NW; g++) begin : g_slot
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst) word_q <= '0;
      else if (cap_i) begin
        if (idx_i == IW'(g))       word_q <= data_i;
        else if (idx_i == '0)      word_q <= '0;
      end
    end
    assign words_o[g*DW +: DW] = word_q;
  end
endmodule

// File: rtl/fcmd_decoder.sv
module fcmd_decoder
  import fcmd_pkg::*;
#(
  parameter int AW = 21,
  parameter int DW = 16,
  parameter int NW = 4,
  parameter int CMP_W = 11,
  parameter int CFG_BIT = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic            busy_i,
  output logic [1:0]      rd_mode_o,
  output logic            pgm_start_o,
  output logic            dwp_start_o,
  output logic            qwp_start_o,
  output logic            cfg_start_o,
  output logic [AW-1:0]   op_addr_o,
  output logic [NW*DW-1:0] op_data_o,
  output logic            cfg_pd_o
);
  localparam int IW = $clog2(NW);
  localparam int DWORDS = 2;

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PGM, S_CFG, S_MW, S_BYP} st_t;

  st_t           st;
  rmode_t        mode;
  logic [IW-1:0] cnt;
  logic          quad, in_byp;
  logic          acc, is_unl1, is_unl2, mismatch, last, cap;
  logic [IW-1:0] idx;
  cmd_t          cmd;

  fcmd_classify #(.CMP_W(CMP_W)) cls_i (
    .addr_i(wr_addr_i[CMP_W-1:0]), .code_i(wr_data_i[7:0]),
    .is_unl1_o(is_unl1), .is_unl2_o(is_unl2), .cmd_o(cmd)
  );

  assign acc  = wr_en_i && !busy_i && (mode != RM_QUERY) && (mode != RM_ASEL);
  assign last = quad ? (cnt == IW'(NW - 1)) : (cnt == IW'(DWORDS - 1));
  assign idx  = (st == S_MW) ? cnt : '0;
  assign cap  = acc && ((st == S_PGM) || (st == S_CFG) ||
                        ((st == S_MW) && (cnt == '0 || !mismatch)));

  fcmd_operand_buf #(.AW(AW), .DW(DW), .NW(NW)) buf_i (
    .clk(clk), .rst(rst), .cap_i(cap), .idx_i(idx), .quad_i(quad),
    .addr_i(wr_addr_i), .data_i(wr_data_i),
    .mismatch_o(mismatch), .base_o(op_addr_o), .words_o(op_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; mode <= RM_ARRAY; cnt <= '0; quad <= 1'b0; in_byp <= 1'b0;
      pgm_start_o <= 1'b0; dwp_start_o <= 1'b0; qwp_start_o <= 1'b0;
      cfg_start_o <= 1'b0; cfg_pd_o <= 1'b0;
    end else begin
      pgm_start_o <= 1'b0; dwp_start_o <= 1'b0; qwp_start_o <= 1'b0; cfg_start_o <= 1'b0;
      if (wr_en_i && !busy_i && !acc) begin
        mode <= RM_ARRAY; st <= S_IDLE; in_byp <= 1'b0;
      end else if (acc) begin
        unique case (st)
          S_IDLE: begin
            if (is_unl1) st <= S_U1;
            else mode <= (cmd == CK_QUERY) ? RM_QUERY : RM_ARRAY;
          end
          S_U1: begin
            if (is_unl2) st <= S_U2;
            else begin st <= S_IDLE; mode <= RM_ARRAY; end
          end
          S_U2: begin
            st <= S_IDLE;
            unique case (cmd)
              CK_ASEL: mode <= RM_ASEL;
              CK_CFG:  st <= S_CFG;
              CK_PGM:  st <= S_PGM;
              CK_DWP:  begin st <= S_MW; quad <= 1'b0; cnt <= '0; in_byp <= 1'b0; end
              CK_QWP:  begin st <= S_MW; quad <= 1'b1; cnt <= '0; in_byp <= 1'b0; end
              CK_BYP:  begin st <= S_BYP; in_byp <= 1'b1; end
              default: mode <= RM_ARRAY;
            endcase
          end
          S_CFG: begin
            cfg_start_o <= 1'b1; cfg_pd_o <= wr_addr_i[CFG_BIT];
            st <= S_IDLE; mode <= RM_ARRAY;
          end
          S_PGM: begin
            pgm_start_o <= 1'b1; st <= S_IDLE; mode <= RM_STATUS;
          end
          S_MW: begin
            if (cnt != '0 && mismatch) begin
              st <= S_IDLE; mode <= RM_ARRAY; in_byp <= 1'b0; cnt <= '0;
            end else if (last) begin
              if (quad) qwp_start_o <= 1'b1;
              else      dwp_start_o <= 1'b1;
              mode <= RM_STATUS; cnt <= '0;
              st <= in_byp ? S_BYP : S_IDLE;
            end else cnt <= cnt + 1'b1;
          end
          S_BYP: begin
            if (cmd == CK_DWP) begin st <= S_MW; quad <= 1'b0; cnt <= '0; end
            else begin st <= S_IDLE; mode <= RM_ARRAY; in_byp <= 1'b0; end
          end
          default: begin st <= S_IDLE; mode <= RM_ARRAY; end
        endcase
      end
    end
  end

  assign rd_mode_o = mode;
endmodule

// File: rtl/fcmd_decoder_chk.sv
module fcmd_decoder_chk #(
  parameter int AW = 21,
  parameter int CFG_BIT = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en_i,
  input logic          busy_i,
  input logic [1:0]    rd_mode_o,
  input logic          pgm_start_o,
  input logic          dwp_start_o,
  input logic          qwp_start_o,
  input logic          cfg_start_o,
  input logic [AW-1:0] op_addr_o,
  input logic          cfg_pd_o
);
  logic [3:0] starts;
  assign starts = {cfg_start_o, qwp_start_o, dwp_start_o, pgm_start_o};

  a_r1_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_mode_o == 2'd0 && starts == 4'd0 && !cfg_pd_o));

  a_r1_quiet_without_write: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> (starts == 4'd0 && $stable(rd_mode_o)));

  a_r13_busy_ignored: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> (starts == 4'd0 && $stable(rd_mode_o) && $stable(cfg_pd_o)));

  a_r8_single_start: assert property (@(posedge clk) disable iff (rst)
    $onehot0(starts));

  a_r8_status_on_program: assert property (@(posedge clk) disable iff (rst)
    (pgm_start_o || dwp_start_o || qwp_start_o) |-> rd_mode_o == 2'd3);

  a_r7_cfg_bit_from_addr: assert property (@(posedge clk) disable iff (rst)
    cfg_start_o |-> (cfg_pd_o == op_addr_o[CFG_BIT] && rd_mode_o == 2'd0));
endmodule

bind fcmd_decoder fcmd_decoder_chk #(.AW(AW), .CFG_BIT(CFG_BIT)) chk_i (
  .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .busy_i(busy_i), .rd_mode_o(rd_mode_o),
  .pgm_start_o(pgm_start_o), .dwp_start_o(dwp_start_o), .qwp_start_o(qwp_start_o),
  .cfg_start_o(cfg_start_o), .op_addr_o(op_addr_o), .cfg_pd_o(cfg_pd_o)
);

// File: tb/fcmd_decoder_tb_top.sv
module fcmd_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [20:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy = 1'b0;
  logic [1:0]  rd_mode;
  logic        pgm_s, dwp_s, qwp_s, cfg_s, cfg_pd;
  logic [20:0] op_addr;
  logic [63:0] op_data;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int          m_st = 0;   // 0 idle 1 u1 2 u2 3 pgm 4 cfg 5 multi 6 bypass
  int          m_mode = 0;
  int          m_cnt = 0;
  int          m_quad = 0;
  int          m_byp = 0;
  int          m_pd = 0;
  logic [20:0] m_base = '0;
  logic [15:0] m_w [4];
  logic [3:0]  e_start = '0; // {cfg, qwp, dwp, pgm}

  always #10 clk = ~clk;

  fcmd_decoder dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .busy_i(busy), .rd_mode_o(rd_mode), .pgm_start_o(pgm_s), .dwp_start_o(dwp_s),
    .qwp_start_o(qwp_s), .cfg_start_o(cfg_s), .op_addr_o(op_addr), .op_data_o(op_data),
    .cfg_pd_o(cfg_pd)
  );

  task automatic check(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    check(cur_req, "rd_mode", rd_mode, m_mode);
    check(cur_req, "starts", {cfg_s, qwp_s, dwp_s, pgm_s}, e_start);
    check("R7", "cfg_pd", cfg_pd, m_pd);
    if (e_start != 0) begin
      check(cur_req, "op_addr", op_addr, m_base);
      for (int k = 0; k < 4; k++) check(cur_req, "op_word", op_data[16*k +: 16], m_w[k]);
    end
  endtask

  task automatic capture(int k, logic [20:0] a, logic [15:0] d);
    if (k == 0) begin
      m_base = a;
      for (int j = 0; j < 4; j++) m_w[j] = '0;
    end
    m_w[k] = d;
  endtask

  task automatic model(bit we, bit bsy, logic [20:0] a, logic [15:0] d);
    logic [7:0]  c;
    logic [10:0] lo;
    logic [20:0] mask;
    c = d[7:0]; lo = a[10:0];
    e_start = '0;
    if (!we || bsy) return;
    if (m_mode == 1 || m_mode == 2) begin
      m_mode = 0; m_st = 0; m_byp = 0; return;
    end
    case (m_st)
      0: if (lo == 11'h555 && c == 8'hAA) m_st = 1;
         else m_mode = (c == 8'h98) ? 1 : 0;
      1: if (lo == 11'h2AA && c == 8'h55) m_st = 2;
         else begin m_st = 0; m_mode = 0; end
      2: begin
        m_st = 0;
        if (c == 8'h90) m_mode = 2;
        else if (c == 8'h60) m_st = 4;
        else if (c == 8'hA0) m_st = 3;
        else if (c == 8'h50) begin m_st = 5; m_quad = 0; m_cnt = 0; m_byp = 0; end
        else if (c == 8'h56) begin m_st = 5; m_quad = 1; m_cnt = 0; m_byp = 0; end
        else if (c == 8'h20) begin m_st = 6; m_byp = 1; end
        else m_mode = 0;
      end
      3: begin capture(0, a, d); e_start = 4'b0001; m_mode = 3; m_st = 0; end
      4: begin capture(0, a, d); e_start = 4'b1000; m_pd = a[10]; m_mode = 0; m_st = 0; end
      5: begin
        mask = m_quad ? 21'd3 : 21'd1;
        if (m_cnt != 0 && ((a ^ m_base) & ~mask) != 0) begin
          m_st = 0; m_mode = 0; m_byp = 0; m_cnt = 0;
        end else begin
          capture(m_cnt, a, d);
          if (m_cnt == (m_quad ? 3 : 1)) begin
            e_start = m_quad ? 4'b0100 : 4'b0010;
            m_mode = 3; m_cnt = 0; m_st = m_byp ? 6 : 0;
          end else m_cnt++;
        end
      end
      default: if (c == 8'h50) begin m_st = 5; m_quad = 0; m_cnt = 0; end
               else begin m_st = 0; m_mode = 0; m_byp = 0; end
    endcase
  endtask

  task automatic cyc(bit we, logic [20:0] a, logic [15:0] d, bit bsy = 0);
    @(negedge clk);
    compare();
    wr_en = we; wr_addr = a; wr_data = d; busy = bsy;
    model(we, bsy, a, d);
  endtask

  task automatic wr(logic [20:0] a, logic [15:0] d);
    cyc(1'b1, a, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, '0);
  endtask

  task automatic unlock();
    wr(21'h00555, 16'h00AA);
    wr(21'h002AA, 16'h0055);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state, directly
    check("R1", "reset mode", rd_mode, 0);
    check("R1", "reset starts", {cfg_s, qwp_s, dwp_s, pgm_s}, 0);
    check("R1", "reset cfg_pd", cfg_pd, 0);
    idle(2);

    cur_req = "R4"; wr(21'h12345, 16'h00F0); unlock(); wr(21'h0, 16'h00F0); idle(1);
    cur_req = "R5"; wr(21'h00055, 16'h0098); idle(1);
    check("R5", "query mode", rd_mode, 1);
    unlock(); wr(21'h0, 16'h00A0); wr(21'h00100, 16'h1234); idle(2);
    cur_req = "R6"; unlock(); wr(21'h1F000, 16'h0090); idle(1);
    check("R6", "autoselect mode", rd_mode, 2);
    wr(21'h0, 16'h00F0); idle(1);
    cur_req = "R7"; unlock(); wr(21'h0, 16'h0060); wr(21'h00523, 16'h0000); idle(1);
    unlock(); wr(21'h0, 16'h0060); wr(21'h0A123, 16'h0000); idle(1);
    cur_req = "R8"; unlock(); wr(21'h0, 16'h00A0); wr(21'h1ABCD, 16'hBEEF); idle(2);
    cur_req = "R13"; cyc(1'b1, 21'h0, 16'h00F0, 1'b1); cyc(1'b1, 21'h0, 16'h00F0, 1'b1); idle(1);
    check("R13", "status kept while busy", rd_mode, 3);
    cur_req = "R4"; wr(21'h0, 16'h00F0); idle(1);
    cur_req = "R13"; wr(21'h00555, 16'h00AA); cyc(1'b1, 21'h00777, 16'h0011, 1'b1);
    wr(21'h002AA, 16'h0055); wr(21'h0, 16'h00A0); wr(21'h00042, 16'h5A5A); idle(2);
    wr(21'h0, 16'h00F0);
    cur_req = "R9"; unlock(); wr(21'h0, 16'h0050); wr(21'h00100, 16'h1111); wr(21'h00101, 16'h2222); idle(2);
    cur_req = "R10"; unlock(); wr(21'h0, 16'h0056);
    for (int k = 0; k < 4; k++) wr(21'h02000 + 21'(3 - k), 16'hA000 + 16'(k));
    idle(2);
    cur_req = "R11"; unlock(); wr(21'h0, 16'h0050); wr(21'h00300, 16'h0001); wr(21'h00310, 16'h0002); idle(2);
    unlock(); wr(21'h0, 16'h0056); wr(21'h00400, 16'h1); wr(21'h00401, 16'h2); wr(21'h00406, 16'h3); wr(21'h00407, 16'h4); idle(2);
    cur_req = "R12"; unlock(); wr(21'h0, 16'h0020);
    for (int r = 0; r < 2; r++) begin
      wr(21'h0, 16'h0050); wr(21'h00800 + 21'(2*r), 16'hC000 + 16'(r));
      wr(21'h00801 + 21'(2*r), 16'hD000 + 16'(r)); idle(1);
    end
    wr(21'h0, 16'h00F0); wr(21'h0, 16'h0050); wr(21'h00900, 16'h7777); wr(21'h00901, 16'h8888); idle(2);
    check("R12", "no start after bypass exit", {cfg_s, qwp_s, dwp_s, pgm_s}, 0);
    cur_req = "R3"; wr(21'h00554, 16'h00AA); wr(21'h002AA, 16'h0055); wr(21'h0, 16'h00A0); wr(21'h00010, 16'h0F0F); idle(1);
    wr(21'h00555, 16'h00AA); wr(21'h002AA, 16'h0056); wr(21'h0, 16'h00A0); wr(21'h00011, 16'h0F0F); idle(1);
    unlock(); wr(21'h0, 16'h0033); wr(21'h00012, 16'h00A0); idle(1);
    cur_req = "R2"; wr(21'h1F555, 16'h12AA); wr(21'h0A2AA, 16'h3455); wr(21'h15555, 16'hFFA0);
    wr(21'h00ABC, 16'h4321); idle(2);
    check("R2", "status after masked unlock", rd_mode, 3);
    idle(1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule